// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block collects eight interrupt requests and ranks them with a fixed priority, where input 0 ranks highest. It raises a single interrupt line to a processor and, on acknowledge, answers with an 8-bit vector. A small byte-wide register port with one address bit programs the block. Software first writes a setup sequence that gives the vector base, the cascade wiring and the end-of-interrupt mode. After that it can write the mask, choose which status byte a read returns, and retire in-service levels with specific or non-specific end-of-interrupt commands.

Two instances can be chained. A master marks in a bitmap which of its inputs carry slaves. When it acknowledges such an input, it puts that input number on its cascade outputs and supplies no vector. The slave whose programmed identity matches the cascade inputs supplies the vector instead. Each input is edge or level sensitive according to a per-input select. When a request vanishes before acknowledge, the block answers with the lowest-priority vector and records nothing in service.

The acknowledge is a one-cycle pulse on `ack`. The vector appears with `vec_vld` in the following cycle. Register writes and reads are single-cycle strobes qualified by `cs`.

Top module: `pic_ctrl`

## Requirements
- R1: After reset `irq_out` is 0 and a mask read (addr=1) returns 0x00.
- R2: An addr=0 write with bit 4 set starts setup. The following addr=1 writes are taken as base, then cascade byte (only if bit 1 of the start byte is 0), then mode byte (only if bit 0 is 1). `irq_out` stays 0 until the last of these is written. Setup clears the mask and the in-service set, selects pending readback, and rearms edge inputs so that each must go low and then high again.
- R3: Acknowledging input n returns the vector {base[7:3], n}. The low three bits of the base byte are ignored.
- R4: Once running, an addr=1 write loads the mask (1 = masked) and an addr=1 read returns it. A masked input never raises `irq_out`.
- R5: Among eligible requests, the lowest-numbered input wins the acknowledge.
- R6: A request raises `irq_out` only if no in-service bit is set at its own level or any higher-priority level.
- R7: An addr=0 write of 0x0B makes addr=0 reads return the in-service byte. A write of 0x0A makes them return the pending byte. The choice persists across other writes.
- R8: An addr=0 write of 0x60+n clears only in-service bit n.
- R9: An addr=0 write of 0x20 clears the highest-priority (lowest-numbered) set in-service bit.
- R10: With mode byte bit 1 set (0x03), an acknowledge leaves the in-service set unchanged.
- R11: With `lvl_sel[n]`=0 an input requests only after a rising edge, and it stays consumed once acknowledged while still held high. With `lvl_sel[n]`=1 it requests whenever it is high.
- R12: An acknowledge with no eligible request returns {base[7:3], 7} with `vec_vld`=1 and sets no in-service bit, even when input 7 is masked.
- R13: A master (`is_master`=1) acknowledging input n whose cascade-byte bit n is 1 drives `cas_out`=n with `cas_oe`=1 during `ack` and gives `vec_vld`=0.
- R14: A slave (`is_master`=0) responds to `ack` only when `cas_in` equals cascade-byte bits [2:0]. Otherwise it returns no vector and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Register port select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not reading |
| req | input | 8 | Interrupt requests |
| lvl_sel | input | 8 | Per-input trigger select, 1 = level |
| is_master | input | 1 | Cascade role, 1 = master |
| ack | input | 1 | One-cycle acknowledge pulse |
| cas_in | input | 3 | Cascade identity seen by a slave |
| irq_out | output | 1 | Interrupt to processor |
| vec | output | 8 | Acknowledge vector |
| vec_vld | output | 1 | Vector valid, cycle after `ack` |
| cas_out | output | 3 | Cascade identity driven by a master |
| cas_oe | output | 1 | `cas_out` valid |

## Verification
The bench targets requests that vanish before acknowledge. A design that gets this wrong would mark a phantom level in service or return a real input's vector instead of level 7. It checks that an edge input held high after acknowledge does not request again, and that setup rearms edges; a faulty design would loop on one interrupt. It stacks two in-service levels to show that a non-specific end-of-interrupt retires only the higher one. It also drives non-matching cascade identities, where a faulty slave would answer an acknowledge meant for another device. Random request and mask patterns with interleaved end-of-interrupt commands cross-check nesting against a bench priority model.

// File: rtl/pic_pkg.sv
// Shared setup-state encoding for the interrupt controller.
package pic_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // never set up
        ST_BASE = 3'd1,   // awaiting base byte
        ST_LINK = 3'd2,   // awaiting cascade byte
        ST_MODE = 3'd3,   // awaiting mode byte
        ST_RUN  = 3'd4    // operational
    } setup_t;
endpackage

// File: rtl/pic_regs.sv
// Register port decode: setup sequence, mask, readback select and
// end-of-interrupt command strobes. Assumes one-cycle cs&wr strobes.
module pic_regs #(
    parameter int N_IN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              wr,
    input  logic              addr,
    input  logic [7:0]        wdata,
    output logic [N_IN-1:0]   mask_q,
    output logic [7:0]        base_q,
    output logic [7:0]        link_q,
    output logic              auto_eoi_q,
    output logic              show_svc_q,
    output logic              running,
    output logic              setup_pulse,
    output logic              eoi_spec,
    output logic              eoi_any
);
    import pic_pkg::*;
    localparam int IDX_W = $clog2(N_IN);

    setup_t state_q;
    logic   single_q, want_mode_q;
    logic   wr_even, wr_odd;

    assign wr_even     = cs && wr && !addr;
    assign wr_odd      = cs && wr && addr;
    assign running     = (state_q == ST_RUN);
    assign setup_pulse = wr_even && wdata[4];
    assign eoi_spec    = running && wr_even && wdata[4:3] == 2'b00 && wdata[7:5] == 3'b011;
    assign eoi_any     = running && wr_even && wdata[4:3] == 2'b00 && wdata[7:5] == 3'b001;

    // Sequence the setup bytes and hold the programmed configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            mask_q      <= '0;
            base_q      <= '0;
            link_q      <= '0;
            auto_eoi_q  <= 1'b0;
            show_svc_q  <= 1'b0;
            single_q    <= 1'b0;
            want_mode_q <= 1'b0;
        end else if (setup_pulse) begin
            state_q     <= ST_BASE;
            single_q    <= wdata[1];
            want_mode_q <= wdata[0];
            mask_q      <= '0;
            show_svc_q  <= 1'b0;
            auto_eoi_q  <= 1'b0;
        end else if (wr_odd) begin
            case (state_q)
                ST_BASE: begin
                    base_q  <= {wdata[7:IDX_W], {IDX_W{1'b0}}};
                    state_q <= !single_q ? ST_LINK : (want_mode_q ? ST_MODE : ST_RUN);
                end
                ST_LINK: begin
                    link_q  <= wdata;
                    state_q <= want_mode_q ? ST_MODE : ST_RUN;
                end
                ST_MODE: begin
                    auto_eoi_q <= wdata[1];
                    state_q    <= ST_RUN;
                end
                ST_RUN:  mask_q <= wdata[N_IN-1:0];
                default: state_q <= state_q;
            endcase
        end else if (running && wr_even && wdata[4:3] == 2'b01 && wdata[1]) begin
            show_svc_q <= wdata[0];
        end
    end
endmodule

// File: rtl/pic_req.sv
// Request capture: one lane per input, level or rising-edge sensitive.
// A captured edge is dropped when the input falls or the lane is acknowledged.
module pic_req #(
    parameter int N_IN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] req,
    input  logic [N_IN-1:0] lvl_sel,
    input  logic            rearm,
    input  logic [N_IN-1:0] taken,
    output logic [N_IN-1:0] pend_q
);
    logic [N_IN-1:0] prev_q;

    for (genvar g = 0; g < N_IN; g++) begin : g_lane
        // Track the previous input value and the pending flag of this lane.
        always_ff @(posedge clk) begin
            if (!rst_n || rearm) begin
                prev_q[g] <= 1'b1;
                pend_q[g] <= 1'b0;
            end else begin
                prev_q[g] <= req[g];
                if (lvl_sel[g])
                    pend_q[g] <= req[g];
                else
                    pend_q[g] <= ((pend_q[g] && !taken[g]) || !prev_q[g]) && req[g];
            end
        end
    end
endmodule

// File: rtl/pic_prio.sv
// Fixed-priority resolver: input 0 highest. A request is eligible only if
// unmasked and no in-service bit is set at its level or above.
module pic_prio #(
    parameter int N_IN = 8
) (
    input  logic [N_IN-1:0]         pend,
    input  logic [N_IN-1:0]         mask,
    input  logic [N_IN-1:0]         svc,
    output logic                    any,
    output logic [$clog2(N_IN)-1:0] win,
    output logic [$clog2(N_IN)-1:0] svc_top,
    output logic                    svc_any
);
    localparam int IDX_W = $clog2(N_IN);

    // Scan from highest priority for the winner and the top in-service level.
    always_comb begin
        logic blocked;
        any     = 1'b0;
        win     = '0;
        svc_top = '0;
        svc_any = 1'b0;
        blocked = 1'b0;
        for (int i = 0; i < N_IN; i++) begin
            if (svc[i] && !svc_any) begin
                svc_any = 1'b1;
                svc_top = IDX_W'(i);
            end
            if (!blocked && !any) begin
                if (svc[i])
                    blocked = 1'b1;
                else if (pend[i] && !mask[i]) begin
                    any = 1'b1;
                    win = IDX_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/pic_ctrl.sv
// Top: cascadable priority interrupt controller. Holds the in-service set,
// runs the acknowledge, and drives vector and cascade outputs.
// Assumes ack is a single-cycle pulse; the vector follows one cycle later.
module pic_ctrl #(
    parameter int N_IN = 8,
    parameter int CAS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic             rd,
    input  logic             wr,
    input  logic             addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    input  logic [N_IN-1:0]  req,
    input  logic [N_IN-1:0]  lvl_sel,
    input  logic             is_master,
    input  logic             ack,
    input  logic [CAS_W-1:0] cas_in,
    output logic             irq_out,
    output logic [7:0]       vec,
    output logic             vec_vld,
    output logic [CAS_W-1:0] cas_out,
    output logic             cas_oe
);
    localparam int IDX_W = $clog2(N_IN);

    logic [N_IN-1:0]  mask_q, pend_q, svc_q, taken;
    logic [7:0]       base_q, link_q;
    logic             auto_eoi, show_svc, running, setup_pulse, eoi_spec, eoi_any;
    logic             any, svc_any, slave_hit, take, via_link;
    logic [IDX_W-1:0] win, svc_top;

    pic_regs #(.N_IN(N_IN)) u_regs (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .addr(addr), .wdata(wdata),
        .mask_q(mask_q), .base_q(base_q), .link_q(link_q), .auto_eoi_q(auto_eoi),
        .show_svc_q(show_svc), .running(running), .setup_pulse(setup_pulse),
        .eoi_spec(eoi_spec), .eoi_any(eoi_any)
    );

    pic_req #(.N_IN(N_IN)) u_req (
        .clk(clk), .rst_n(rst_n), .req(req), .lvl_sel(lvl_sel),
        .rearm(setup_pulse), .taken(taken), .pend_q(pend_q)
    );

    pic_prio #(.N_IN(N_IN)) u_prio (
        .pend(pend_q), .mask(mask_q), .svc(svc_q), .any(any), .win(win),
        .svc_top(svc_top), .svc_any(svc_any)
    );

    assign slave_hit = !is_master && (cas_in == link_q[CAS_W-1:0]);
    assign take      = running && ack && (is_master || slave_hit);
    assign via_link  = is_master && any && link_q[win];
    assign taken     = (take && any) ? (N_IN'(1) << win) : '0;
    assign irq_out   = running && any;
    assign cas_oe    = take && via_link;
    assign cas_out   = cas_oe ? CAS_W'(win) : '0;

    // Read mux: mask on addr=1, pending or in-service byte on addr=0.
    always_comb begin
        rdata = '0;
        if (cs && rd)
            rdata = addr ? mask_q : (show_svc ? svc_q : pend_q);
    end

    // Maintain the in-service set: mark on acknowledge, retire on EOI.
    always_ff @(posedge clk) begin
        if (!rst_n || setup_pulse) begin
            svc_q <= '0;
        end else begin
            if (eoi_spec)
                svc_q[wdata[IDX_W-1:0]] <= 1'b0;
            else if (eoi_any && svc_any)
                svc_q[svc_top] <= 1'b0;
            if (take && any && !auto_eoi)
                svc_q[win] <= 1'b1;
        end
    end

    // Register the vector returned in the cycle after acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec     <= '0;
            vec_vld <= 1'b0;
        end else begin
            vec_vld <= take && !via_link;
            if (take)
                vec <= {base_q[7:IDX_W], any ? win : {IDX_W{1'b1}}};
        end
    end
endmodule

// File: rtl/pic_ctrl_chk.sv
// Property checker for pic_ctrl, attached by bind below.
module pic_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ack,
    input logic [2:0] cas_in,
    input logic       is_master,
    input logic       irq_out,
    input logic       cas_oe,
    input logic       vec_vld,
    input logic [7:0] vec,
    input logic       cs,
    input logic       wr,
    input logic       running,
    input logic       auto_eoi,
    input logic [7:0] svc,
    input logic [7:0] link
);
    a_r2_quiet_until_run: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !irq_out);

    a_r10_auto_keeps_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (running && auto_eoi) |-> svc == 8'h00);

    a_r6_ack_adds_one_level: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_out && is_master && !auto_eoi && !(cs && wr))
        |=> $countones(svc) == $countones($past(svc)) + 1);

    a_r12_spurious_level7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && running && is_master && !irq_out) |=> (vec_vld && vec[2:0] == 3'd7));

    a_r13_cascade_no_vector: assert property (@(posedge clk) disable iff (!rst_n)
        cas_oe |=> !vec_vld);

    a_r14_slave_mismatch_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !is_master && cas_in != link[2:0]) |=> !vec_vld);
endmodule

bind pic_ctrl pic_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ack(ack), .cas_in(cas_in), .is_master(is_master),
    .irq_out(irq_out), .cas_oe(cas_oe), .vec_vld(vec_vld), .vec(vec), .cs(cs),
    .wr(wr), .running(running), .auto_eoi(auto_eoi), .svc(svc_q), .link(link_q)
);

// File: tb/pic_ctrl_tb.sv
`timescale 1ns/1ps
module pic_ctrl_tb;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic       cs = 0, rd = 0, wr = 0, addr = 0, is_master = 1, ack = 0;
    logic [7:0] wdata = 0, req = 0, lvl_sel = 8'hFF;
    logic [2:0] cas_in = 0;
    logic [7:0] rdata, vec;
    logic       irq_out, vec_vld, cas_oe;
    logic [2:0] cas_out;
    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pic_ctrl u_dut (.clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .req(req), .lvl_sel(lvl_sel), .is_master(is_master),
        .ack(ack), .cas_in(cas_in), .irq_out(irq_out), .vec(vec), .vec_vld(vec_vld),
        .cas_out(cas_out), .cas_oe(cas_oe));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_reg(input logic a, input logic [7:0] d);
        @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk); cs = 0; wr = 0; #1;
    endtask

    task automatic rd_reg(input logic a, output logic [7:0] d);
        cs = 1; rd = 1; addr = a; #1; d = rdata; cs = 0; rd = 0; #1;
    endtask

    task automatic rd_svc(output logic [7:0] d);
        wr_reg(0, 8'h0B); rd_reg(0, d);
    endtask

    task automatic do_ack(output logic oe, output logic [2:0] cs_o,
                          output logic vv, output logic [7:0] vc);
        @(negedge clk); ack = 1; #1; oe = cas_oe; cs_o = cas_out;
        @(negedge clk); ack = 0; #1; vv = vec_vld; vc = vec;
    endtask

    task automatic setup(input logic [7:0] base, input logic [7:0] link, input logic [7:0] mode);
        wr_reg(0, 8'h11); wr_reg(1, base); wr_reg(1, link); wr_reg(1, mode);
    endtask

    // Bench priority model: winner index, or 8 when none is eligible.
    function automatic int m_win(logic [7:0] p, logic [7:0] m, logic [7:0] s);
        for (int i = 0; i < 8; i++) begin
            if (s[i]) return 8;
            if (p[i] && !m[i]) return i;
        end
        return 8;
    endfunction

    function automatic logic [7:0] m_clr_top(logic [7:0] s);
        for (int i = 0; i < 8; i++) if (s[i]) return s & ~(8'h01 << i);
        return s;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, vc, mk, svc_m, rq, vexp;
        logic oe, vv;
        logic [2:0] co;
        int w, r;
        void'($urandom(32'd7));
        tick(3); rst_n = 1; #1;
        chk("R1 irq after reset", irq_out, 0);
        rd_reg(1, d); chk("R1 mask after reset", d, 8'h00);
        req = 8'h01; tick(2);
        chk("R2 no irq before setup", irq_out, 0);

        // Partial setup keeps the line quiet; completion enables it.
        wr_reg(0, 8'h11); wr_reg(1, 8'h20); wr_reg(1, 8'h04); tick(1);
        chk("R2 quiet mid-setup", irq_out, 0);
        wr_reg(1, 8'h01);
        chk("R2 irq after setup", irq_out, 1);
        rd_reg(1, d); chk("R2 mode byte not taken as mask", d, 8'h00);
        do_ack(oe, co, vv, vc);
        chk("R3 vector valid", vv, 1); chk("R3 vector input0", vc, 8'h20);

        // Readback selection persists.
        wr_reg(0, 8'h0B); rd_reg(0, d); chk("R7 in-service read", d, 8'h01);
        wr_reg(1, 8'h00); rd_reg(0, d); chk("R7 select persists", d, 8'h01);
        wr_reg(0, 8'h0A); rd_reg(0, d); chk("R7 pending read", d, 8'h01);

        // In-service level 0 blocks level 1.
        req = 8'h02; tick(2);
        chk("R6 blocked by higher in-service", irq_out, 0);
        wr_reg(0, 8'h60); tick(1);
        chk("R8 specific EOI unblocks", irq_out, 1);
        do_ack(oe, co, vv, vc); chk("R3 vector input1", vc, 8'h21);
        req = 8'h03; tick(2);
        chk("R6 higher priority nests", irq_out, 1);
        do_ack(oe, co, vv, vc); chk("R5 lowest index wins", vc, 8'h20);
        rd_svc(d); chk("R6 two levels in service", d, 8'h03);
        wr_reg(0, 8'h20); rd_svc(d); chk("R9 clears top level only", d, 8'h02);
        wr_reg(0, 8'h61); wr_reg(0, 8'h0B); wr_reg(0, 8'h62); rd_reg(0, d);
        chk("R8 specific EOI of unset level", d, 8'h00);

        // Mask.
        req = 8'h01; wr_reg(1, 8'h01); tick(1);
        chk("R4 masked input quiet", irq_out, 0);
        rd_reg(1, d); chk("R4 mask readback", d, 8'h01);

        // Spurious: request disappears before acknowledge, input 7 masked.
        wr_reg(1, 8'h80); tick(1);
        chk("R12 request seen", irq_out, 1);
        req = 8'h00; tick(2);
        chk("R12 request gone", irq_out, 0);
        do_ack(oe, co, vv, vc);
        chk("R12 spurious valid", vv, 1); chk("R12 spurious vector", vc, 8'h27);
        rd_svc(d); chk("R12 nothing in service", d, 8'h00);
        wr_reg(1, 8'h00);

        // Edge versus level.
        lvl_sel = 8'h00; tick(2);
        req = 8'h08; tick(2);
        chk("R11 edge request", irq_out, 1);
        do_ack(oe, co, vv, vc); chk("R11 edge vector", vc, 8'h23);
        wr_reg(0, 8'h63); tick(1);
        chk("R11 held edge consumed", irq_out, 0);
        lvl_sel = 8'h08; tick(2);
        chk("R11 level re-requests", irq_out, 1);
        lvl_sel = 8'h00; tick(1);
        setup(8'h20, 8'h04, 8'h01); tick(1);
        chk("R2 setup rearms edges", irq_out, 0);
        req = 8'h00; tick(1); req = 8'h08; tick(2);
        chk("R11 new edge after rearm", irq_out, 1);

        // Automatic end of interrupt.
        setup(8'h20, 8'h04, 8'h03);
        req = 8'h00; tick(1); req = 8'h10; tick(2);
        do_ack(oe, co, vv, vc); chk("R10 auto vector", vc, 8'h24);
        rd_svc(d); chk("R10 no in-service mark", d, 8'h00);

        // Master acknowledging a slave-bearing input.
        lvl_sel = 8'hFF; setup(8'h20, 8'h04, 8'h01);
        req = 8'h04; tick(2);
        do_ack(oe, co, vv, vc);
        chk("R13 cascade enable", oe, 1); chk("R13 cascade id", co, 2);
        chk("R13 no vector from master", vv, 0);

        // Slave role.
        is_master = 0; setup(8'h28, 8'h02, 8'h01);
        req = 8'h20; tick(2);
        cas_in = 3'd3; do_ack(oe, co, vv, vc);
        chk("R14 mismatched id silent", vv, 0);
        rd_svc(d); chk("R14 mismatched id no state", d, 8'h00);
        cas_in = 3'd2; do_ack(oe, co, vv, vc);
        chk("R14 matched id answers", vv, 1); chk("R14 slave vector", vc, 8'h2D);
        is_master = 1;

        // Random nesting against the model; base low bits must be ignored (R3).
        setup(8'h47, 8'h00, 8'h01);
        wr_reg(0, 8'h0B);
        svc_m = 8'h00;
        for (int it = 0; it < 400; it++) begin
            rq = 8'($urandom); mk = 8'($urandom) & 8'($urandom);
            @(negedge clk); req = rq;
            wr_reg(1, mk); tick(1);
            w = m_win(rq, mk, svc_m);
            chk("R5 R6 random irq", irq_out, (w < 8) ? 1 : 0);
            if ($urandom % 2 == 0) begin
                do_ack(oe, co, vv, vc);
                vexp = 8'h40 | ((w < 8) ? 8'(w) : 8'd7);
                chk("R3 R5 random vector", vc, vexp);
                if (w < 8) svc_m[w] = 1'b1;
            end
            r = $urandom % 3;
            if (r == 0) begin
                wr_reg(0, 8'h20); svc_m = m_clr_top(svc_m);
            end else if (r == 1) begin
                w = $urandom % 8;
                wr_reg(0, 8'h60 | 8'(w)); svc_m[w] = 1'b0;
            end
            rd_reg(0, d); chk("R8 R9 random in-service", d, svc_m);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule